// File: doc/BRIEF.md
# Silence-Delimited Serial Frame Receiver

This block sits behind a UART character receiver that has already checked parity. It cuts the incoming byte stream into RTU-style frames using only the idle time on the line, because the frames contain no delimiter characters. A free-running idle timer advances on an input `tick`, one pulse per bit period. With 11 bit periods per character, the defaults are 17 ticks for about 1.5 characters and 39 ticks for about 3.5 characters.

The first byte of every frame is compared with the configured station address. A matching frame is streamed out one byte at a time, marked with a start pulse and later an end pulse. The end pulse carries the frame length and a good/bad verdict. That verdict combines a CRC-valid level from an external CRC engine with the block's own checks: minimum length, parity, overflow and inter-frame gap. A frame addressed elsewhere is swallowed with no output. A frame that begins before the line has been quiet for the full inter-frame gap raises a gap error.

Top module: `rtu_gap_rx`

## Requirements
- R1: After reset all pulse outputs (`frm_start`, `byte_valid`, `frm_end`, `frm_good`, `runt_err`, `gap_err`) are low and `frm_len` is 0. The line is treated as already quiet, so the first frame after reset raises no gap error.
- R2: Every byte of an accepted frame appears on `byte_data` with `byte_valid` high for one cycle, one clock after its `rx_valid` cycle. The first byte of the frame (the address) also pulses `frm_start`.
- R3: A frame closes when END_TICKS ticks have passed with no byte since its last byte (default 17). A byte that arrives sooner joins the current frame. At the close, `frm_end` pulses for one cycle for an accepted frame.
- R4: If a frame's first byte arrives fewer than GAP_TICKS ticks after the previous byte (default 39), `gap_err` pulses with that byte, whatever the address, and that frame ends with `frm_good` low.
- R5: A frame is accepted only when its first byte equals `cfg_addr` and `cfg_addr` lies in 1..16. Any other frame produces no `frm_start`, `byte_valid`, `frm_end` or `runt_err`.
- R6: An accepted frame with fewer than 4 bytes ends with `frm_good` low and `runt_err` pulsing together with `frm_end`.
- R7: If `rx_perr` is high with any byte of an accepted frame, that frame ends with `frm_good` low.
- R8: `frm_good` requires `crc_ok` to be high on the clock edge at which the frame closes.
- R9: At most MAX_LEN bytes (default 256) of a frame are delivered. Further bytes are dropped, `frm_len` stops at MAX_LEN and the frame ends with `frm_good` low.
- R10: The idle timer advances only on cycles with `tick` high. While `tick` stays low, an open frame never closes.
- R11: At `frm_end`, `frm_len` holds the number of bytes delivered for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One pulse per bit period; advances the idle timer |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error on the character this cycle |
| cfg_addr | input | 8 | Station address, valid range 1..16 |
| crc_ok | input | 1 | CRC verdict from the external CRC engine |
| frm_start | output | 1 | First byte of an accepted frame |
| byte_valid | output | 1 | `byte_data` holds a delivered byte |
| byte_data | output | 8 | Delivered byte |
| frm_end | output | 1 | Accepted frame has closed |
| frm_good | output | 1 | With `frm_end`: frame passed every check |
| frm_len | output | 9 | Byte count of the current or last frame |
| runt_err | output | 1 | With `frm_end`: frame shorter than 4 bytes |
| gap_err | output | 1 | Frame began before the full inter-frame gap |

## Verification
The bench places inter-character spacing on both sides of the close threshold, 16 and 17 idle ticks. A design whose timer is off by one would merge two frames or split one. It also probes the inter-frame gap at 38 and 39 ticks, where a miscounted timer would flag a legal gap or miss an illegal one. Frames of exactly 4 and 3 bytes test the runt limit. A 260-byte burst tests the storage cap: a wrong cap delivers too many bytes or lets the length wrap. The bench also sets out-of-range station addresses and holds `tick` low to show that the timer does not run on plain clocks.

// File: rtl/rtu_gap_rx.sv
module rtu_gap_rx #(
  parameter int END_TICKS = 17,
  parameter int GAP_TICKS = 39,
  parameter int MAX_LEN   = 256,
  parameter int ADDR_MIN  = 1,
  parameter int ADDR_MAX  = 16,
  localparam int IW = $clog2(GAP_TICKS + 1),
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_perr,
  input  logic [7:0]    cfg_addr,
  input  logic          crc_ok,
  output logic          frm_start,
  output logic          byte_valid,
  output logic [7:0]    byte_data,
  output logic          frm_end,
  output logic          frm_good,
  output logic [LW-1:0] frm_len,
  output logic          runt_err,
  output logic          gap_err
);

  logic [IW-1:0] idle;
  logic          in_frame, acc, bad;

  wire addr_ok   = (cfg_addr >= 8'(ADDR_MIN)) && (cfg_addr <= 8'(ADDR_MAX));
  wire hit       = addr_ok && (rx_data == cfg_addr);
  wire short_gap = idle < IW'(GAP_TICKS);
  wire len_full  = frm_len == LW'(MAX_LEN);
  wire close_now = in_frame && !rx_valid && tick && (idle == IW'(END_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle       <= IW'(GAP_TICKS);
      in_frame   <= 1'b0;
      acc        <= 1'b0;
      bad        <= 1'b0;
      frm_len    <= '0;
      byte_data  <= '0;
      frm_start  <= 1'b0;
      byte_valid <= 1'b0;
      frm_end    <= 1'b0;
      frm_good   <= 1'b0;
      runt_err   <= 1'b0;
      gap_err    <= 1'b0;
    end else begin
      frm_start  <= 1'b0;
      byte_valid <= 1'b0;
      frm_end    <= 1'b0;
      frm_good   <= 1'b0;
      runt_err   <= 1'b0;
      gap_err    <= 1'b0;

      if (rx_valid)
        idle <= '0;
      else if (tick && idle != IW'(GAP_TICKS))
        idle <= idle + 1'b1;

      if (rx_valid) begin
        byte_data <= rx_data;
        if (!in_frame) begin
          in_frame   <= 1'b1;
          acc        <= hit;
          bad        <= rx_perr | short_gap;
          frm_len    <= LW'(1);
          frm_start  <= hit;
          byte_valid <= hit;
          gap_err    <= short_gap;
        end else if (len_full) begin
          bad <= 1'b1;
        end else begin
          frm_len    <= frm_len + 1'b1;
          byte_valid <= acc;
          bad        <= bad | rx_perr;
        end
      end else if (close_now) begin
        in_frame <= 1'b0;
        frm_end  <= acc;
        frm_good <= acc && crc_ok && !bad && (frm_len >= LW'(4));
        runt_err <= acc && (frm_len < LW'(4));
      end
    end
  end

endmodule

// File: rtl/rtu_gap_rx_chk.sv
module rtu_gap_rx_chk #(
  parameter int MAX_LEN = 256,
  localparam int LW = $clog2(MAX_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          rx_valid,
  input logic [7:0]    rx_data,
  input logic          crc_ok,
  input logic          frm_start,
  input logic          byte_valid,
  input logic [7:0]    byte_data,
  input logic          frm_end,
  input logic          frm_good,
  input logic [LW-1:0] frm_len,
  input logic          runt_err,
  input logic          gap_err
);

  assert_start_has_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> byte_valid);

  assert_byte_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(rx_valid) && byte_data == $past(rx_data));

  assert_end_after_silence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> !byte_valid && !$past(rx_valid));

  assert_gap_on_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    gap_err |-> $past(rx_valid));

  assert_runt_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    runt_err |-> frm_end && !frm_good && frm_len < LW'(4));

  assert_good_needs_crc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_good |-> frm_end && $past(crc_ok));

  assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_len <= LW'(MAX_LEN));

  assert_end_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_end |-> $past(tick));

endmodule

bind rtu_gap_rx rtu_gap_rx_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_valid(rx_valid), .rx_data(rx_data),
  .crc_ok(crc_ok), .frm_start(frm_start), .byte_valid(byte_valid),
  .byte_data(byte_data), .frm_end(frm_end), .frm_good(frm_good),
  .frm_len(frm_len), .runt_err(runt_err), .gap_err(gap_err)
);

// File: tb/test_rtu_gap_rx.sv
`timescale 1ns/1ps
module test_rtu_gap_rx;
  logic clk = 0, rst_n = 0, tick = 1, rx_valid = 0, rx_perr = 0, crc_ok = 0;
  logic [7:0] rx_data = 0, cfg_addr = 8'd5;
  logic frm_start, byte_valid, frm_end, frm_good, runt_err, gap_err;
  logic [7:0] byte_data;
  logic [8:0] frm_len;

  always #2 clk = ~clk;

  rtu_gap_rx i_rtu_gap_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .cfg_addr(cfg_addr), .crc_ok(crc_ok),
    .frm_start(frm_start), .byte_valid(byte_valid), .byte_data(byte_data),
    .frm_end(frm_end), .frm_good(frm_good), .frm_len(frm_len),
    .runt_err(runt_err), .gap_err(gap_err)
  );

  // event counters: 0 start, 1 bytes, 2 end, 3 good, 4 runt, 5 gap
  int ev[6];
  int base[6];
  int bsum = 0, bsum0 = 0, end_len = 0, first_byte = 0;
  int errors = 0, checks = 0;

  always @(negedge clk) begin
    if (frm_start) begin ev[0] += 1; first_byte = int'(byte_data); end
    if (byte_valid) begin ev[1] += 1; bsum += int'(byte_data); end
    if (frm_end) begin ev[2] += 1; end_len = int'(frm_len); end
    if (frm_good) ev[3] += 1;
    if (runt_err) ev[4] += 1;
    if (gap_err) ev[5] += 1;
  end

  task automatic mark();
    for (int i = 0; i < 6; i++) base[i] = ev[i];
    bsum0 = bsum;
  endtask

  function automatic int d(int i);
    return ev[i] - base[i];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b, logic p);
    rx_valid = 1; rx_data = b; rx_perr = p;
    @(negedge clk);
    rx_valid = 0; rx_perr = 0;
  endtask

  task automatic quiet(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] body(int i, logic [7:0] a);
    return (i == 0) ? a : 8'(i * 37 + 1);
  endfunction

  task automatic frame(logic [7:0] a, int n, int perr_at, int sp);
    for (int i = 0; i < n; i++) begin
      put(body(i, a), logic'(i == perr_at));
      if (i != n - 1) quiet(sp);
    end
  endtask

  typedef struct packed {
    logic [7:0] addr;
    logic [8:0] n;
    logic [8:0] perr_at;
    logic       crc;
    logic       e_start;
    logic [8:0] e_bytes;
    logic       e_end;
    logic       e_good;
    logic       e_runt;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd5, 9'd6, 9'h1FF, 1'b1, 1'b1, 9'd6, 1'b1, 1'b1, 1'b0},  // R2 R8 R11 clean frame
    '{8'd5, 9'd6, 9'h1FF, 1'b0, 1'b1, 9'd6, 1'b1, 1'b0, 1'b0},  // R8 crc bad
    '{8'd5, 9'd4, 9'h1FF, 1'b1, 1'b1, 9'd4, 1'b1, 1'b1, 1'b0},  // R6 shortest legal
    '{8'd5, 9'd3, 9'h1FF, 1'b1, 1'b1, 9'd3, 1'b1, 1'b0, 1'b1},  // R6 runt
    '{8'd7, 9'd6, 9'h1FF, 1'b1, 1'b0, 9'd0, 1'b0, 1'b0, 1'b0},  // R5 other station
    '{8'd5, 9'd8, 9'd2,   1'b1, 1'b1, 9'd8, 1'b1, 1'b0, 1'b0},  // R7 parity
    '{8'd5, 9'd1, 9'h1FF, 1'b1, 1'b1, 9'd1, 1'b1, 1'b0, 1'b1},  // R6 single byte
    '{8'd7, 9'd2, 9'h1FF, 1'b1, 1'b0, 9'd0, 1'b0, 1'b0, 1'b0}   // R5 short, foreign
  };

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 6; i++) begin ev[i] = 0; base[i] = 0; end
    quiet(5);
    chk("R1 frm_len", int'(frm_len), 0);
    chk("R1 pulses", int'({frm_start, byte_valid, frm_end, frm_good, runt_err, gap_err}), 0);
    rst_n = 1;

    foreach (VEC[k]) begin
      int exp_sum;
      exp_sum = 0;
      crc_ok = VEC[k].crc;
      mark();
      frame(VEC[k].addr, int'(VEC[k].n), int'(VEC[k].perr_at), 3);
      quiet(60);
      if (VEC[k].e_bytes != 0)
        for (int i = 0; i < int'(VEC[k].n); i++) exp_sum += int'(body(i, VEC[k].addr));
      chk($sformatf("R2 R5 start v%0d", k), d(0), int'(VEC[k].e_start));
      chk($sformatf("R2 bytes v%0d", k), d(1), int'(VEC[k].e_bytes));
      chk($sformatf("R2 data sum v%0d", k), bsum - bsum0, exp_sum);
      chk($sformatf("R3 end v%0d", k), d(2), int'(VEC[k].e_end));
      chk($sformatf("R7 R8 good v%0d", k), d(3), int'(VEC[k].e_good));
      chk($sformatf("R6 runt v%0d", k), d(4), int'(VEC[k].e_runt));
      chk($sformatf("R1 R4 no gap v%0d", k), d(5), 0);
      if (VEC[k].e_end) chk($sformatf("R11 len v%0d", k), end_len, int'(VEC[k].n));
      if (VEC[k].e_start) chk($sformatf("R2 first v%0d", k), first_byte, int'(VEC[k].addr));
    end

    // R3: 16 idle ticks between bytes keep one frame
    crc_ok = 1; mark();
    frame(8'd5, 5, -1, 16); quiet(60);
    chk("R3 spacing16 ends", d(2), 1);
    chk("R11 spacing16 len", end_len, 5);
    chk("R3 spacing16 good", d(3), 1);

    // R3 R4: 17 idle ticks split; second part is foreign and too early
    mark();
    put(8'd5, 0); quiet(17);
    frame(8'd38, 4, -1, 1); quiet(60);
    chk("R3 split ends", d(2), 1);
    chk("R6 split runt", d(4), 1);
    chk("R4 split gap", d(5), 1);
    chk("R5 split foreign bytes", d(1), 1);

    // R4: gap of 38 ticks is too short
    mark();
    frame(8'd5, 4, -1, 1); quiet(38);
    frame(8'd5, 4, -1, 1); quiet(60);
    chk("R4 gap38 err", d(5), 1);
    chk("R4 gap38 good", d(3), 1);
    chk("R4 gap38 ends", d(2), 2);

    // R4: gap of 39 ticks is legal
    mark();
    frame(8'd5, 4, -1, 1); quiet(39);
    frame(8'd5, 4, -1, 1); quiet(60);
    chk("R4 gap39 err", d(5), 0);
    chk("R4 gap39 good", d(3), 2);

    // R9: overflow
    mark();
    frame(8'd5, 260, -1, 1); quiet(60);
    chk("R9 bytes", d(1), 256);
    chk("R9 len", end_len, 256);
    chk("R9 good", d(3), 0);
    chk("R9 end", d(2), 1);

    // R5: out-of-range station addresses match nothing
    mark();
    cfg_addr = 8'd0;  frame(8'd0, 5, -1, 1);  quiet(60);
    cfg_addr = 8'd17; frame(8'd17, 5, -1, 1); quiet(60);
    chk("R5 invalid start", d(0), 0);
    chk("R5 invalid end", d(2), 0);
    chk("R5 invalid bytes", d(1), 0);
    cfg_addr = 8'd16; frame(8'd16, 5, -1, 1); quiet(60);
    chk("R5 addr16 good", d(3), 1);
    cfg_addr = 8'd1; mark();
    frame(8'd1, 4, -1, 1); quiet(60);
    chk("R5 addr1 good", d(3), 1);

    // R10: no tick, no close
    mark();
    frame(8'd1, 4, -1, 1);
    tick = 0; quiet(100);
    chk("R10 held open", d(2), 0);
    tick = 1; quiet(30);
    chk("R10 closes on ticks", d(2), 1);
    chk("R10 good", d(3), 1);

    finish_up();
  end
endmodule